// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps the rows of a two-bank asynchronous DRAM alive. A free-running interval timer marks a refresh as due every `INTERVAL` clock cycles; the default of 1560 cycles at 100 MHz gives one refresh per 15.6 µs, which spreads 2048 row refreshes across a 32 ms retention window. Due refreshes collect in a saturating pending counter while the host side holds the memory bus, so refreshes can be postponed and later drained in one burst.

The block asks the access sequencer for the bus with a request/grant handshake that behaves like a valid/ready pair: `ref_req` is the valid side and `ref_gnt` the ready side. While grant stays low the request stays high and the pending count keeps growing up to `MAX_PEND`, at which point `ref_urgent` rises; no refresh is lost before saturation. Once request and grant are both high at a clock edge, the block owns the bus from the next cycle, drains every pending refresh back to back, and ignores grant until it releases the bus after the final precharge. In the default CAS-before-RAS mode it drops CAS, waits `T_CSR` cycles, then pulses both bank RAS lines together once per refresh while CAS stays low across the whole burst and WE stays high. With `ras_only_sel` high at grant time it instead keeps CAS high and places an internal row counter on the address bus while RAS pulses.

All DRAM outputs carry meaning only while `bus_own` is high; otherwise they sit at their inactive levels so the sequencer can merge them with its own strobes.

Top module: `rfsh_sched`

## Requirements
- R1: After reset the pending count is zero and `ref_req` is low; the first refresh becomes due `INTERVAL` clock edges after reset is released, so `ref_req` is still low after `INTERVAL-1` edges and high after `INTERVAL` edges.
- R2: While refreshes are pending and `ref_gnt` is low, `ref_req` stays high and `bus_own` stays low; when `ref_req` and `ref_gnt` are both high at an edge, `bus_own` is high from that edge on.
- R3: The pending count saturates at `MAX_PEND`; a granted burst issues exactly as many refresh pulses as were pending (0 pending gives no burst even with grant high).
- R4: `ref_urgent` is high exactly when the pending count equals `MAX_PEND`, and it clears once the burst has drained the count.
- R5: In CAS-before-RAS mode (`ras_only_sel` = 0 at grant) CAS goes low when the bus is taken and RAS first falls `T_CSR` cycles later; `dram_we_n` is 1 for the whole burst.
- R6: Every refresh holds RAS low for exactly `T_RAS` cycles and consecutive pulses are separated by exactly `T_RP` high cycles; in CAS-before-RAS mode CAS stays low for the entire burst, including between pulses.
- R7: All bits of `dram_ras_n` carry the same value in every cycle, so both banks refresh together.
- R8: In RAS-only mode (`ras_only_sel` = 1 at grant) CAS stays high, the row address is `T_CSR` cycles ahead of the first RAS fall, and each pulse presents the row counter, which starts at 0 after reset, advances by one per RAS-only refresh and carries over between bursts.
- R9: The mode is captured at grant; changing `ras_only_sel` during a burst does not alter that burst.
- R10: A burst of n refreshes holds `bus_own` for exactly `T_CSR + n*(T_RAS+T_RP)` cycles; whenever `bus_own` is low, every `dram_ras_n` bit and `dram_cas_n` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_only_sel | input | 1 | 1 selects RAS-only refresh, 0 CAS-before-RAS; sampled at grant |
| ref_gnt | input | 1 | Bus grant from the access sequencer (ready side) |
| ref_req | output | 1 | Bus request (valid side), high while refreshes are pending or the bus is owned |
| ref_urgent | output | 1 | Pending count has reached its limit |
| bus_own | output | 1 | Block is driving the DRAM strobes and address |
| dram_ras_n | output | NBANK | Row strobes, active low, one per bank |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low, held high by this block |
| dram_addr | output | ROW_W | Row address for RAS-only refresh, 0 otherwise |

## Verification
The bench goes after the saturation edge of the pending counter: bursts after one to seven deferred intervals must yield exactly min(k, `MAX_PEND`) pulses, so a counter that wraps past its limit would produce far too few pulses and one that drops the tick arriving on a decrement would miscount. It measures each RAS low and high phase and the CAS-to-RAS lead, which catches a sequencer that raises CAS between back-to-back pulses (a CAS-before-RAS cycle would then lose its setup and be seen as a normal access) or counts its phases off by one. In RAS-only mode it follows the row address across two separate bursts, exposing a counter that resets per burst or advances in the wrong mode, and it flips the mode pin mid-burst to expose a design that reads the pin live instead of latching it at grant.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Phases of one refresh burst.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // bus not owned
    ST_SETUP = 2'd1,  // CAS low (CBR) or row valid (RAS-only), RAS high
    ST_ACT   = 2'd2,  // RAS low
    ST_PRE   = 2'd3   // RAS high, precharge
  } rfsh_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= RELOAD;
    end else if (tick) begin
      cnt <= RELOAD;
    end else begin
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/rfsh_pending_ctr.sv
module rfsh_pending_ctr #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic due,     // one refresh became due
  input  logic issued,  // one refresh completed
  output logic nonzero,
  output logic full
);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam logic [PW-1:0] LIMIT = PW'(MAX_PEND);

  logic [PW-1:0] level;

  assign nonzero = (level != '0);
  assign full    = (level == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
    end else begin
      unique case ({due, issued})
        2'b10:   if (!full) level <= level + PW'(1);
        2'b01:   if (nonzero) level <= level - PW'(1);
        default: level <= level;  // both or neither: net unchanged
      endcase
    end
  end
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row <= '0;
    end else if (step) begin
      row <= row + ROW_W'(1);
    end
  end
endmodule

// File: rtl/rfsh_seq_fsm.sv
module rfsh_seq_fsm
  import rfsh_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_RAS = 6,
  parameter int T_RP  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pend_nz,
  input  logic        gnt,
  input  logic        mode_sel,
  output rfsh_state_e state,
  output logic        mode_q,
  output logic        ras_done
);
  localparam int TMAX = max3(T_CSR, T_RAS, T_RP);
  localparam int CW   = (TMAX > 1) ? $clog2(TMAX) : 1;
  localparam logic [CW-1:0] LD_CSR = CW'(T_CSR - 1);
  localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);

  logic [CW-1:0] cnt;
  logic          phase_end;

  assign phase_end = (cnt == '0);
  assign ras_done  = (state == ST_ACT) && phase_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      mode_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pend_nz && gnt) begin
            state  <= ST_SETUP;
            cnt    <= LD_CSR;
            mode_q <= mode_sel;
          end
        end
        ST_SETUP: begin
          if (phase_end) begin
            state <= ST_ACT;
            cnt   <= LD_RAS;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_ACT: begin
          if (phase_end) begin
            state <= ST_PRE;
            cnt   <= LD_RP;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_PRE: begin
          if (phase_end) begin
            // Drain back to back while work remains; CAS untouched.
            if (pend_nz) begin
              state <= ST_ACT;
              cnt   <= LD_RAS;
            end else begin
              state <= ST_IDLE;
              cnt   <= '0;
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int NBANK    = 2,
  parameter int ROW_W    = 11,
  parameter int INTERVAL = 1560,
  parameter int MAX_PEND = 8,
  parameter int T_CSR    = 1,
  parameter int T_RAS    = 6,
  parameter int T_RP     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_only_sel,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ref_urgent,
  output logic             bus_own,
  output logic [NBANK-1:0] dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic [ROW_W-1:0] dram_addr
);
  logic        tick;
  logic        pend_nz;
  logic        pend_full;
  logic        ras_done;
  logic        burst_ras_only;
  logic [ROW_W-1:0] row;
  rfsh_state_e state;
  logic        ras_active;

  rfsh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  rfsh_pending_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .due     (tick),
    .issued  (ras_done),
    .nonzero (pend_nz),
    .full    (pend_full)
  );

  rfsh_seq_fsm #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_nz  (pend_nz),
    .gnt      (ref_gnt),
    .mode_sel (ras_only_sel),
    .state    (state),
    .mode_q   (burst_ras_only),
    .ras_done (ras_done)
  );

  rfsh_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (ras_done && burst_ras_only),
    .row   (row)
  );

  assign bus_own    = (state != ST_IDLE);
  assign ref_req    = pend_nz || bus_own;
  assign ref_urgent = pend_full;
  assign ras_active = (state == ST_ACT);

  // One strobe per bank, all driven from the same phase.
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign dram_ras_n[b] = ~ras_active;
  end

  assign dram_cas_n = ~(bus_own && !burst_ras_only);
  assign dram_we_n  = 1'b1;
  assign dram_addr  = (bus_own && burst_ras_only) ? row : '0;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int NBANK = 2,
  parameter int T_RAS = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_req,
  input logic             ref_gnt,
  input logic             ref_urgent,
  input logic             bus_own,
  input logic [NBANK-1:0] dram_ras_n,
  input logic             dram_cas_n,
  input logic             burst_ras_only
);
  logic [7:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (!dram_ras_n[0]) low_run <= low_run + 8'd1;
    else low_run <= '0;
  end

  a_r7_banks_together: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n == '0) || (dram_ras_n == '1));

  a_r10_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> ((&dram_ras_n) && dram_cas_n));

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt && !bus_own) |=> ref_req);

  a_r2_own_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt && !bus_own) |=> bus_own);

  a_r4_urgent_requests: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> ref_req);

  a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_own && !burst_ras_only && $fell(dram_ras_n[0])) |-> (!dram_cas_n && $past(!dram_cas_n)));

  a_r8_ras_only_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_own && burst_ras_only) |-> dram_cas_n);

  a_r6_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n[0]) |-> (low_run == 8'(T_RAS)));
endmodule

bind rfsh_sched rfsh_sched_chk #(.NBANK(NBANK), .T_RAS(T_RAS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ref_req        (ref_req),
  .ref_gnt        (ref_gnt),
  .ref_urgent     (ref_urgent),
  .bus_own        (bus_own),
  .dram_ras_n     (dram_ras_n),
  .dram_cas_n     (dram_cas_n),
  .burst_ras_only (burst_ras_only)
);

// File: tb/rfsh_sched_test.sv
module rfsh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 2;
  localparam int RW   = 11;
  localparam int IVL  = 60;
  localparam int MAXP = 4;
  localparam int TCSR = 2;
  localparam int TRAS = 6;
  localparam int TRP  = 5;

  // {intervals waited, ras_only, expected pulses}
  localparam int NVEC = 7;
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 0}, '{1, 0, 1}, '{3, 0, 3}, '{4, 0, 4},
    '{7, 0, 4}, '{2, 1, 2}, '{6, 1, 4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_only_sel = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, ref_urgent, bus_own, dram_cas_n, dram_we_n;
  logic [NB-1:0] dram_ras_n;
  logic [RW-1:0] dram_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfsh_sched #(.NBANK(NB), .ROW_W(RW), .INTERVAL(IVL), .MAX_PEND(MAXP),
               .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)) uut (
    .clk(clk), .rst_n(rst_n), .ras_only_sel(ras_only_sel), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .bus_own(bus_own),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr)
  );

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Grant the bus and watch one whole burst.
  task automatic observe_burst(input int exp_n, input bit ro, input int flip_at,
                               input int row0, input string tag);
    int cyc = 0, pulses = 0, lo = 0, hi = 0, first_fall = -1;
    int bad_w = 0, bad_gap = 0, bad_cas = 0, bad_bank = 0, bad_we = 0, bad_addr = 0;
    bit prev_ras = 1'b1;
    ref_gnt = 1'b1;
    @(negedge clk);
    check({tag, " R2 own one cycle after grant"}, int'(bus_own), 1);
    while (bus_own && cyc < 400) begin
      if (dram_ras_n[0] != dram_ras_n[1]) bad_bank++;
      if (dram_we_n !== 1'b1) bad_we++;
      if (dram_cas_n !== ro) bad_cas++;
      if (prev_ras && !dram_ras_n[0]) begin
        if (pulses == 0) first_fall = cyc;
        if (ro && dram_addr !== RW'(row0 + pulses)) bad_addr++;
        if (pulses > 0 && hi != TRP) bad_gap++;
        lo = 0;
      end
      if (!prev_ras && dram_ras_n[0]) begin
        pulses++;
        if (lo != TRAS) bad_w++;
        hi = 0;
      end
      if (!dram_ras_n[0]) lo++; else hi++;
      prev_ras = dram_ras_n[0];
      cyc++;
      if (cyc == flip_at) ras_only_sel = ~ras_only_sel;
      @(negedge clk);
    end
    ref_gnt = 1'b0;
    check({tag, " R3 pulse count"}, pulses, exp_n);
    check({tag, " R10 own length"}, cyc, TCSR + exp_n * (TRAS + TRP));
    check({tag, " R5/R8 lead to first RAS fall"}, first_fall, TCSR);
    check({tag, " R6 RAS low width"}, bad_w, 0);
    check({tag, " R6 RAS gap"}, bad_gap, 0);
    check({tag, " R6/R8 CAS level in burst"}, bad_cas, 0);
    check({tag, " R7 banks together"}, bad_bank, 0);
    check({tag, " R5 WE high"}, bad_we, 0);
    check({tag, " R8 row address"}, bad_addr, 0);
    check({tag, " R10 idle RAS after release"}, int'(&dram_ras_n), 1);
    check({tag, " R10 idle CAS after release"}, int'(dram_cas_n), 1);
    check({tag, " R4 urgent cleared"}, int'(ref_urgent), 0);
    check({tag, " R3 request cleared"}, int'(ref_req), 0);
  endtask

  initial begin
    // Table-driven bursts
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      tag = $sformatf("vec%0d", v);
      ras_only_sel = VEC[v][1][0];
      do_reset();
      repeat (VEC[v][0] * IVL + 3) @(negedge clk);
      check({tag, " R2 request pending"}, int'(ref_req), int'(VEC[v][0] > 0));
      check({tag, " R4 urgent at limit"}, int'(ref_urgent), int'(VEC[v][0] >= MAXP));
      check({tag, " R2 no own before grant"}, int'(bus_own), 0);
      if (VEC[v][0] == 0) begin
        ref_gnt = 1'b1;
        repeat (5) @(negedge clk);
        check({tag, " R3 no burst when none pending"}, int'(bus_own), 0);
        ref_gnt = 1'b0;
      end else begin
        observe_burst(VEC[v][2], VEC[v][1][0], -1, 0, tag);
      end
    end

    // Reset state and first due time (R1)
    ras_only_sel = 1'b0;
    do_reset();
    check("R1 reset request", int'(ref_req), 0);
    check("R1 reset own", int'(bus_own), 0);
    check("R10 reset strobes", int'(&dram_ras_n & dram_cas_n & dram_we_n), 1);
    repeat (IVL - 1) @(negedge clk);
    check("R1 not yet due", int'(ref_req), 0);
    @(negedge clk);
    check("R1 due after interval", int'(ref_req), 1);

    // Row counter carries across bursts (R8)
    ras_only_sel = 1'b1;
    do_reset();
    repeat (2 * IVL + 3) @(negedge clk);
    observe_burst(2, 1'b1, -1, 0, "r8_first");
    repeat (40) @(negedge clk);
    observe_burst(1, 1'b1, -1, 2, "r8_second");

    // Mode pin flipped mid-burst is ignored (R9)
    ras_only_sel = 1'b0;
    do_reset();
    repeat (2 * IVL + 3) @(negedge clk);
    observe_burst(2, 1'b0, 3, 0, "r9_cbr_flip");
    ras_only_sel = 1'b1;
    do_reset();
    repeat (2 * IVL + 3) @(negedge clk);
    observe_burst(2, 1'b1, 5, 0, "r9_ro_flip");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule